// File: doc/BRIEF.md
# Mixed-Width I2C Register Target

This block is an I2C target that gives an on-chip register bank a serial front door. A controller addresses it with a fixed 7-bit target address and then sends a two-byte register sub-address, high byte first. What happens next depends on the direction.

- **Write.** The controller streams the data bytes. The block assembles them into a word and commits the word to the internal register port only once the final byte of the access has been acknowledged.
- **Read.** The controller issues a repeated START and the target address with the read bit. The block fetches the word once and shifts it out.

The number of data bytes in an access is not negotiated. It follows only from the sub-address range:

- The low and high windows hold 16-bit registers, which take two bytes.
- The middle window holds 32-bit registers, which take four bytes.

On the wire, a word travels as its low halfword first, and each halfword is sent most significant byte first.

A write to the system-control address also drives a hold-in-reset output for the surrounding logic.

SCL and SDA are oversampled by the system clock. SDA is open drain: `sda_oe` high pulls the line low.

The controller is a single state machine:

- **ST_IDLE:** waits for a START.
- **ST_RX:** shifts in eight bits on SCL rising edges.
  - Leaves to **ST_RX_ACK** on the falling edge after the eighth bit.
  - Leaves to **ST_SKIP** instead if the address byte does not match.
- **ST_RX_ACK:** holds SDA low for the acknowledge clock.
  - On the following SCL fall it moves to **ST_TX** when a read was addressed.
  - Otherwise it moves back to **ST_RX**.
- **ST_TX:** drives eight bits, each changed on an SCL fall, then releases SDA and moves to **ST_TX_ACK**.
- **ST_TX_ACK:** samples the controller's answer on the SCL rise.
  - An ACK returns to **ST_TX** on the next fall.
  - A NACK moves to **ST_SKIP**.
- **ST_SKIP:** keeps SDA released.
- **Any state:** a START enters **ST_RX** for a fresh address byte, and a STOP returns to **ST_IDLE**.

Top module: `i2c_regbank_target`

## Requirements
- R1: After the address byte with the write bit, the next two bytes form the 16-bit sub-address, high byte first. `reg_addr` presents it for every register access that follows.
- R2: A sub-address below 0x0100 or at or above 0x0600 names a 16-bit register. Such an access moves two data bytes, and `reg_wide` is 0 during it.
- R3: A sub-address from 0x0100 through 0x05FF names a 32-bit register. Such an access moves four data bytes, and `reg_wide` is 1 during it.
- R4: The data-byte order on the wire is bits [15:8], [7:0], [31:24], [23:16]. This holds for reads and writes. A 16-bit write presents bits [31:16] of `reg_wdata` as zero.
- R5: `reg_wr` is a single-cycle pulse raised on the SCL fall that ends the acknowledge of the last data byte. A write stopped before that byte never pulses `reg_wr`.
- R6: Written data bytes beyond the register width are acknowledged and discarded. Read bytes beyond the width return 0xFF.
- R7: A repeated START followed by the address with the read bit (bit 0 = 1) turns the access into a read of the current sub-address. The read works as follows:
  - `reg_rd` pulses for one cycle.
  - `reg_rdata` is taken on the clock edge that ends that cycle.
- R8: The block acknowledges an address byte whose upper seven bits equal `TGT_ADDR` (default 0x0E), and every byte written after it. Any other address is not acknowledged, and the rest of that transfer is ignored. SDA is never pulled low while SCL is high.
- R9: A NACK from the controller after a read byte ends the data phase. SDA stays released until the next START.
- R10: A committed write to 0x0002 sets `core_rst` to bit 0 of the written data: 1 holds the logic in reset, 0 releases it. Writes to other addresses leave `core_rst` unchanged.
- R11: While and after `rst_n` is low, the block holds the following until bus activity: `sda_oe`, `reg_wr`, `reg_rd` and `core_rst` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | I2C clock line level |
| sda_i | input | 1 | I2C data line level |
| sda_oe | output | 1 | 1 pulls SDA low (open drain) |
| reg_addr | output | 16 | Register sub-address of the current access |
| reg_wide | output | 1 | 1 when the addressed register is 32 bits |
| reg_wr | output | 1 | One-cycle write commit strobe |
| reg_wdata | output | 32 | Assembled write word |
| reg_rd | output | 1 | One-cycle read request |
| reg_rdata | input | 32 | Read word, taken at the edge ending `reg_rd` |
| core_rst | output | 1 | Hold-in-reset output set by writes to 0x0002 |

## Verification
The hardest states to reach from the ports are the partial ones:

- a write abandoned by a STOP partway through a 32-bit word;
- a read the controller cuts short with a NACK after one byte;
- a 16-bit access that the controller keeps clocking past its width.

The bench's controller model takes a byte count separate from the register width and lets the last read byte be NACKed at any position, so all three are driven directly. Each is followed by a bus access that observes the register-port model and `core_rst`, showing that no commit slipped through and that the bus returned to idle.

// File: rtl/i2crb_pkg.sv
package i2crb_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_RX_ACK,
        ST_TX,
        ST_TX_ACK,
        ST_SKIP
    } st_e;

    typedef enum logic [1:0] {
        PH_DEV,
        PH_SUB_HI,
        PH_SUB_LO,
        PH_DATA
    } ph_e;

    // Wire byte index -> bit offset inside the word: 0->8, 1->0, 2->24, 3->16
    function automatic logic [4:0] lane_shift(input logic [1:0] idx);
        return {idx[1], ~idx[0], 3'b000};
    endfunction

endpackage

// File: rtl/i2crb_line_mon.sv
module i2crb_line_mon #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [SYNC_STAGES-1:0] scl_pipe, sda_pipe;
    logic scl_q, sda_q, scl_now;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_q    <= 1'b1;
            sda_q    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[SYNC_STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[SYNC_STAGES-2:0], sda_i};
            scl_q    <= scl_pipe[SYNC_STAGES-1];
            sda_q    <= sda_pipe[SYNC_STAGES-1];
        end
    end

    assign scl_now   = scl_pipe[SYNC_STAGES-1];
    assign sda_s     = sda_pipe[SYNC_STAGES-1];
    assign scl_rise  = scl_now & ~scl_q;
    assign scl_fall  = ~scl_now & scl_q;
    assign start_det = scl_now & scl_q & sda_q & ~sda_s;
    assign stop_det  = scl_now & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2crb_ctrl.sv
module i2crb_ctrl
    import i2crb_pkg::*;
#(
    parameter logic [6:0]  TGT_ADDR    = 7'h0E,
    parameter logic [15:0] WIDE_LO     = 16'h0100,
    parameter logic [15:0] WIDE_HI     = 16'h0600,
    parameter logic [15:0] SYSCTL_ADDR = 16'h0002
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        sda_s,
    input  logic        scl_rise,
    input  logic        scl_fall,
    input  logic        start_det,
    input  logic        stop_det,
    output logic        sda_oe,
    output logic [15:0] reg_addr,
    output logic        reg_wide,
    output logic        reg_wr,
    output logic [31:0] reg_wdata,
    output logic        reg_rd,
    input  logic [31:0] reg_rdata,
    output logic        core_rst
);
    localparam logic [3:0] BITS_PER_BYTE = 4'd8;
    localparam logic [2:0] IDX_SAT       = 3'd4;

    st_e         st, nxt;
    ph_e         phase;
    logic [3:0]  bitcnt;
    logic [7:0]  shreg, txsh, cur_byte;
    logic [2:0]  byte_idx, nbytes;
    logic [15:0] sub_addr;
    logic [31:0] wbuf, tx_word;
    logic        tx_go, commit_pend, addr_hit, byte_done;

    assign reg_wide  = (sub_addr >= WIDE_LO) && (sub_addr < WIDE_HI);
    assign nbytes    = reg_wide ? 3'd4 : 3'd2;
    assign reg_addr  = sub_addr;
    assign reg_wdata = wbuf;
    assign addr_hit  = (shreg[7:1] == TGT_ADDR);
    assign byte_done = scl_fall && (bitcnt == BITS_PER_BYTE);

    always_comb begin
        cur_byte = 8'hFF;
        if (byte_idx < nbytes)
            cur_byte = 8'(tx_word >> lane_shift(byte_idx[1:0]));
    end

    // next-state logic
    always_comb begin
        nxt = st;
        unique case (st)
            ST_IDLE:   nxt = ST_IDLE;
            ST_RX:     if (byte_done)
                           nxt = (phase == PH_DEV && !addr_hit) ? ST_SKIP : ST_RX_ACK;
            ST_RX_ACK: if (scl_fall) nxt = tx_go ? ST_TX : ST_RX;
            ST_TX:     if (byte_done) nxt = ST_TX_ACK;
            ST_TX_ACK: if (scl_rise && sda_s) nxt = ST_SKIP;
                       else if (scl_fall) nxt = ST_TX;
            ST_SKIP:   nxt = ST_SKIP;
            default:   nxt = ST_IDLE;
        endcase
        if (start_det)     nxt = ST_RX;
        else if (stop_det) nxt = ST_IDLE;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= nxt;
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase       <= PH_DEV;
            bitcnt      <= '0;
            shreg       <= '0;
            txsh        <= '1;
            byte_idx    <= '0;
            sub_addr    <= '0;
            wbuf        <= '0;
            tx_word     <= '0;
            tx_go       <= 1'b0;
            commit_pend <= 1'b0;
            sda_oe      <= 1'b0;
            reg_wr      <= 1'b0;
            reg_rd      <= 1'b0;
            core_rst    <= 1'b0;
        end else begin
            reg_wr <= 1'b0;
            reg_rd <= 1'b0;
            if (reg_rd) tx_word <= reg_rdata;
            if (start_det) begin
                phase       <= PH_DEV;
                bitcnt      <= '0;
                byte_idx    <= '0;
                tx_go       <= 1'b0;
                commit_pend <= 1'b0;
                sda_oe      <= 1'b0;
            end else if (stop_det) begin
                commit_pend <= 1'b0;
                sda_oe      <= 1'b0;
            end else begin
                unique case (st)
                    ST_RX: begin
                        if (scl_rise) begin
                            shreg  <= {shreg[6:0], sda_s};
                            bitcnt <= bitcnt + 4'd1;
                        end
                        if (byte_done) begin
                            unique case (phase)
                                PH_DEV: if (addr_hit) begin
                                    sda_oe   <= 1'b1;
                                    tx_go    <= shreg[0];
                                    reg_rd   <= shreg[0];
                                    byte_idx <= '0;
                                    phase    <= PH_SUB_HI;
                                end
                                PH_SUB_HI: begin
                                    sda_oe         <= 1'b1;
                                    sub_addr[15:8] <= shreg;
                                    phase          <= PH_SUB_LO;
                                end
                                PH_SUB_LO: begin
                                    sda_oe        <= 1'b1;
                                    sub_addr[7:0] <= shreg;
                                    byte_idx      <= '0;
                                    wbuf          <= '0;
                                    phase         <= PH_DATA;
                                end
                                PH_DATA: begin
                                    sda_oe <= 1'b1;
                                    if (byte_idx < nbytes) begin
                                        wbuf <= wbuf | ({24'b0, shreg} << lane_shift(byte_idx[1:0]));
                                        if (byte_idx == nbytes - 3'd1) commit_pend <= 1'b1;
                                    end
                                    if (byte_idx != IDX_SAT) byte_idx <= byte_idx + 3'd1;
                                end
                                default: ;
                            endcase
                        end
                    end
                    ST_RX_ACK: if (scl_fall) begin
                        bitcnt <= '0;
                        if (tx_go) begin
                            txsh   <= cur_byte;
                            sda_oe <= ~cur_byte[7];
                        end else begin
                            sda_oe <= 1'b0;
                        end
                        if (commit_pend) begin
                            reg_wr      <= 1'b1;
                            commit_pend <= 1'b0;
                            if (sub_addr == SYSCTL_ADDR) core_rst <= wbuf[0];
                        end
                    end
                    ST_TX: begin
                        if (scl_rise) bitcnt <= bitcnt + 4'd1;
                        if (byte_done) begin
                            sda_oe <= 1'b0;
                        end else if (scl_fall) begin
                            sda_oe <= ~txsh[6];
                            txsh   <= {txsh[6:0], 1'b1};
                        end
                    end
                    ST_TX_ACK: begin
                        if (scl_rise && !sda_s && byte_idx != IDX_SAT)
                            byte_idx <= byte_idx + 3'd1;
                        if (scl_fall) begin
                            bitcnt <= '0;
                            txsh   <= cur_byte;
                            sda_oe <= ~cur_byte[7];
                        end
                    end
                    ST_SKIP: sda_oe <= 1'b0;
                    ST_IDLE: sda_oe <= 1'b0;
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/i2c_regbank_target.sv
module i2c_regbank_target #(
    parameter logic [6:0]  TGT_ADDR    = 7'h0E,
    parameter logic [15:0] WIDE_LO     = 16'h0100,
    parameter logic [15:0] WIDE_HI     = 16'h0600,
    parameter logic [15:0] SYSCTL_ADDR = 16'h0002,
    parameter int          SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        scl_i,
    input  logic        sda_i,
    output logic        sda_oe,
    output logic [15:0] reg_addr,
    output logic        reg_wide,
    output logic        reg_wr,
    output logic [31:0] reg_wdata,
    output logic        reg_rd,
    input  logic [31:0] reg_rdata,
    output logic        core_rst
);
    logic sda_s, scl_rise, scl_fall, start_det, stop_det;

    i2crb_line_mon #(.SYNC_STAGES(SYNC_STAGES)) u_mon (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2crb_ctrl #(
        .TGT_ADDR    (TGT_ADDR),
        .WIDE_LO     (WIDE_LO),
        .WIDE_HI     (WIDE_HI),
        .SYSCTL_ADDR (SYSCTL_ADDR)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .sda_oe    (sda_oe),
        .reg_addr  (reg_addr),
        .reg_wide  (reg_wide),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .reg_rd    (reg_rd),
        .reg_rdata (reg_rdata),
        .core_rst  (core_rst)
    );
endmodule

// File: rtl/i2crb_checker.sv
module i2crb_checker #(
    parameter logic [15:0] SYSCTL_ADDR = 16'h0002
) (
    input logic        clk,
    input logic        rst_n,
    input logic        scl_i,
    input logic        sda_oe,
    input logic        reg_wr,
    input logic        reg_rd,
    input logic        reg_wide,
    input logic [31:0] reg_wdata,
    input logic [15:0] reg_addr,
    input logic        core_rst
);
    // R5: commit strobe lasts one cycle
    a_r5_wr_single: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |=> !reg_wr);

    // R7: read request lasts one cycle and never coincides with a commit
    a_r7_rd_single: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd |=> !reg_rd);
    a_r7_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_rd && reg_wr));

    // R4: narrow writes zero-fill the upper halfword
    a_r4_zero_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && !reg_wide) |-> (reg_wdata[31:16] == 16'h0000));

    // R10: core_rst only moves with a commit to the system-control address
    a_r10_rst_src: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(core_rst) |-> (reg_wr && reg_addr == SYSCTL_ADDR));

    // R8: SDA is only pulled low while SCL is low
    a_r8_drive_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_i);
endmodule

bind i2c_regbank_target i2crb_checker #(.SYSCTL_ADDR(SYSCTL_ADDR)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_oe    (sda_oe),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_wide  (reg_wide),
    .reg_wdata (reg_wdata),
    .reg_addr  (reg_addr),
    .core_rst  (core_rst)
);

// File: tb/i2c_regbank_target_tb.sv
module i2c_regbank_target_tb;
    localparam int CLK_PERIOD = 10;
    localparam int Q = 8;
    localparam logic [6:0] DEV = 7'h0E;
    localparam int NVEC = 7;
    localparam logic [47:0] VEC [NVEC] = '{
        {16'h0004, 32'h1234_5678},
        {16'h00FE, 32'hCAFE_F00D},
        {16'h0100, 32'hA5A5_5A5A},
        {16'h05FC, 32'h0123_4567},
        {16'h0600, 32'h89AB_CDEF},
        {16'h0622, 32'h7777_8001},
        {16'h0214, 32'hDEAD_BEEF}
    };

    logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, sda_drv = 1'b1;
    logic sda_oe, reg_wide, reg_wr, reg_rd, core_rst;
    logic [15:0] reg_addr;
    logic [31:0] reg_wdata, reg_rdata;
    logic sda_bus;
    int n_tests = 0, n_fail = 0;
    bit done = 0;

    assign sda_bus = sda_drv & ~sda_oe;
    always #(CLK_PERIOD/2) clk = ~clk;

    i2c_regbank_target u_dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus), .sda_oe(sda_oe),
        .reg_addr(reg_addr), .reg_wide(reg_wide), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
        .core_rst(core_rst)
    );

    // register-port model
    logic [31:0] mem [128];
    int wr_cnt = 0, rd_cnt = 0;
    logic last_wide = 1'b0;
    logic [15:0] last_addr = '0;
    function automatic logic [6:0] midx(input logic [15:0] a);
        return {a[11:8], a[3:1]};
    endfunction
    initial for (int i = 0; i < 128; i++) mem[i] = '0;
    always @(posedge clk) begin
        if (reg_wr) begin
            mem[midx(reg_addr)] <= reg_wdata;
            wr_cnt    <= wr_cnt + 1;
            last_wide <= reg_wide;
            last_addr <= reg_addr;
        end
        if (reg_rd) begin
            rd_cnt    <= rd_cnt + 1;
            last_wide <= reg_wide;
            last_addr <= reg_addr;
        end
    end
    assign reg_rdata = mem[midx(reg_addr)];

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic i2c_start();
        sda_drv = 1'b1; tick(Q); scl = 1'b1; tick(Q);
        sda_drv = 1'b0; tick(Q); scl = 1'b0; tick(Q);
    endtask

    task automatic i2c_stop();
        sda_drv = 1'b0; tick(Q); scl = 1'b1; tick(Q); sda_drv = 1'b1; tick(2*Q);
    endtask

    task automatic wbyte(input logic [7:0] b, output bit ack);
        for (int i = 7; i >= 0; i--) begin
            sda_drv = b[i]; tick(Q); scl = 1'b1; tick(2*Q); scl = 1'b0; tick(Q);
        end
        sda_drv = 1'b1; tick(Q); scl = 1'b1; tick(Q);
        ack = (sda_bus == 1'b0);
        tick(Q); scl = 1'b0; tick(Q);
    endtask

    task automatic rbyte(input bit nack, output logic [7:0] b);
        sda_drv = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            tick(Q); scl = 1'b1; tick(Q); b[i] = sda_bus; tick(Q); scl = 1'b0; tick(Q);
        end
        sda_drv = nack; tick(Q); scl = 1'b1; tick(2*Q); scl = 1'b0; tick(Q);
        sda_drv = 1'b1;
    endtask

    // bytes[8*i +: 8] is wire byte i; returns AND of all acks
    task automatic wr_tx(input logic [15:0] sub, input int n, input logic [63:0] bytes, output bit all_ack);
        bit a;
        i2c_start();
        wbyte({DEV, 1'b0}, a); all_ack = a;
        wbyte(sub[15:8], a); all_ack &= a;
        wbyte(sub[7:0], a);  all_ack &= a;
        for (int i = 0; i < n; i++) begin
            wbyte(bytes[8*i +: 8], a); all_ack &= a;
        end
        i2c_stop();
    endtask

    task automatic rd_tx(input logic [15:0] sub, input int n, output logic [63:0] bytes);
        bit a;
        logic [7:0] b;
        bytes = '0;
        i2c_start();
        wbyte({DEV, 1'b0}, a);
        wbyte(sub[15:8], a);
        wbyte(sub[7:0], a);
        i2c_start();
        wbyte({DEV, 1'b1}, a);
        for (int i = 0; i < n; i++) begin
            rbyte(i == n - 1, b);
            bytes[8*i +: 8] = b;
        end
        i2c_stop();
    endtask

    function automatic logic [63:0] wire_bytes(input logic [31:0] d);
        return {32'h0, d[23:16], d[31:24], d[7:0], d[15:8]};
    endfunction

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin : main
        bit ack;
        logic [63:0] rb;
        int wc;
        tick(5);
        // R11: reset state
        chk(sda_oe == 0 && reg_wr == 0 && reg_rd == 0 && core_rst == 0, "R11 reset outputs",
            {sda_oe, reg_wr, reg_rd, core_rst}, 0);
        rst_n = 1'b1; tick(5);
        chk(sda_oe == 0 && core_rst == 0, "R11 after reset", {sda_oe, core_rst}, 0);

        // vector table: write then read back each register
        for (int v = 0; v < NVEC; v++) begin
            logic [15:0] sub;
            logic [31:0] d, exp;
            bit wide;
            int nb;
            sub  = VEC[v][47:32];
            d    = VEC[v][31:0];
            wide = (sub >= 16'h0100) && (sub < 16'h0600);
            nb   = wide ? 4 : 2;
            exp  = wide ? d : {16'h0, d[15:0]};
            wc   = wr_cnt;
            wr_tx(sub, nb, wire_bytes(d), ack);
            chk(ack, "R8 write bytes acked", 64'(ack), 1);
            chk(wr_cnt == wc + 1, "R5 one commit per write", 64'(wr_cnt - wc), 1);
            chk(last_addr == sub, "R1 sub-address", 64'(last_addr), 64'(sub));
            chk(last_wide == wide, wide ? "R3 wide range" : "R2 narrow range", 64'(last_wide), 64'(wide));
            chk(mem[midx(sub)] == exp, "R4 write byte order", 64'(mem[midx(sub)]), 64'(exp));
            rd_tx(sub, nb, rb);
            chk(rb == (wire_bytes(exp) & (wide ? 64'hFFFF_FFFF : 64'hFFFF)), "R7 R4 read byte order",
                rb, wire_bytes(exp) & (wide ? 64'hFFFF_FFFF : 64'hFFFF));
        end

        // R8: wrong target address is ignored
        wc = wr_cnt;
        i2c_start();
        wbyte({7'h55, 1'b0}, ack);
        chk(!ack, "R8 foreign address not acked", 64'(ack), 0);
        wbyte(8'h00, ack); wbyte(8'h04, ack); wbyte(8'hFF, ack); wbyte(8'hFF, ack);
        i2c_stop();
        chk(wr_cnt == wc && mem[midx(16'h0004)] == 32'h5678, "R8 foreign transfer ignored",
            {32'(wr_cnt - wc), mem[midx(16'h0004)]}, 64'h5678);

        // R5: truncated 32-bit write leaves register unchanged
        wr_tx(16'h0108, 4, wire_bytes(32'h1122_3344), ack);
        wc = wr_cnt;
        wr_tx(16'h0108, 2, wire_bytes(32'hFFFF_FFFF), ack);
        chk(wr_cnt == wc, "R5 truncated write no commit", 64'(wr_cnt - wc), 0);
        chk(mem[midx(16'h0108)] == 32'h1122_3344, "R5 truncated write keeps value",
            64'(mem[midx(16'h0108)]), 64'h1122_3344);

        // R6: extra write bytes acked and discarded, extra read bytes are 0xFF
        wr_tx(16'h0010, 4, 64'hD4C3_B2A1, ack);
        chk(ack, "R6 extra bytes acked", 64'(ack), 1);
        chk(mem[midx(16'h0010)] == 32'h0000_A1B2, "R6 extra bytes discarded",
            64'(mem[midx(16'h0010)]), 64'hA1B2);
        rd_tx(16'h0010, 4, rb);
        chk(rb == 64'hFFFF_B2A1, "R6 read beyond width", rb, 64'hFFFF_B2A1);

        // R9: early NACK ends the read; next access still works
        wc = rd_cnt;
        rd_tx(16'h0100, 1, rb);
        chk(rb[7:0] == 8'h5A, "R9 first byte before NACK", 64'(rb[7:0]), 64'h5A);
        chk(rd_cnt == wc + 1, "R7 one read request", 64'(rd_cnt - wc), 1);
        tick(4*Q);
        chk(sda_oe == 0, "R9 SDA released after NACK", 64'(sda_oe), 0);
        rd_tx(16'h0100, 4, rb);
        chk(rb == wire_bytes(32'hA5A5_5A5A), "R9 next read intact", rb, wire_bytes(32'hA5A5_5A5A));

        // R10: system-control hold-in-reset
        wr_tx(16'h0002, 2, wire_bytes(32'h1), ack);
        chk(core_rst == 1, "R10 hold asserted", 64'(core_rst), 1);
        wr_tx(16'h0004, 2, wire_bytes(32'h0), ack);
        chk(core_rst == 1, "R10 other address no effect", 64'(core_rst), 1);
        wr_tx(16'h0002, 2, wire_bytes(32'h0), ack);
        chk(core_rst == 0, "R10 hold released", 64'(core_rst), 0);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule